// File: doc/BRIEF.md
# Dual-Channel Gate Mode Logic

This block turns a single pulse-width-modulated switching waveform into gate enables for two power switches. It samples the switching waveform through a two-flop synchronizer, detects its rising edges, and drives the two gate enables in one of three selectable patterns. In the same-phase pattern both switches copy the waveform. In the complementary pattern the first switch follows the waveform and the second follows its inverse, with a programmable blanking gap during which both are off. In the alternating pattern consecutive high pulses are routed to one switch and then the other, so each switch runs at half the waveform frequency.

The blanking gap is a count of clock cycles. Writing zero to the count selects a built-in default that corresponds to 150 ns at the configured clock period (30 cycles at 200 MHz). Pattern changes requested on the select input are accepted only while the synchronized waveform is low. After a change, both gates stay off until the next rising edge of the waveform, so no partial pulse is ever produced.

Top module: `gml_gate_mode`

## Requirements
- R1: While reset is high, and after reset until the first rising edge of the synchronized waveform, both gate outputs are low.
- R2: With select 00 (same-phase), both gates equal the waveform input delayed by three clock cycles (two synchronizer stages plus the output register).
- R3: With select 01 (complementary), gate A follows the delayed waveform, gate B follows its inverse, and the two gates are never high in the same cycle.
- R4: In complementary mode a gate rises only after the other gate has been low for the whole blanking gap.
- R5: With a nonzero blanking count N, the gap between one gate falling and the other rising is exactly N cycles, provided the waveform still asks for the rising gate.
- R6: With select 10 (alternating), successive high pulses of the waveform appear on gate A and gate B in turn, and the two gates are never high together.
- R7: Select 11 is reserved: once accepted, both gates stay low.
- R8: A new select value is accepted only while the synchronized waveform is low. After it is accepted, both gates stay low until the next rising edge of the waveform.
- R9: The alternation toggle is cleared by reset and by every accepted mode change, so the first pulse after entering alternating mode goes to gate A.
- R10: A blanking count of zero selects the default gap of 30 cycles (150 ns at a 5 ns clock).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_in | input | 1 | Switching waveform, asynchronous to clk |
| mode_sel | input | 2 | Pattern select: 00 same-phase, 01 complementary, 10 alternating, 11 reserved |
| gap_cycles | input | DT_W (8) | Blanking gap in clock cycles; zero selects the default |
| gate_a | output | 1 | Gate enable for switch A |
| gate_b | output | 1 | Gate enable for switch B |

## Verification
A wrong internal state surfaces at the gates within a few cycles. A stale accepted mode shows as a gate pattern that does not match the select input at the next rising edge. A bad gap counter moves the complementary rising edge by the size of the error, or lets both gates overlap. A toggle that fails to clear or advance sends two consecutive pulses to the same gate, which is visible on the second pulse after alternating mode is entered. The bench runs a behavioural model in lockstep and compares both gates on every cycle. It also measures gap lengths and counts pulses per gate to tie each deviation to a requirement.

// File: rtl/gml_pkg.sv
package gml_pkg;

  typedef enum logic [1:0] {
    GM_SAME = 2'b00,
    GM_COMP = 2'b01,
    GM_ALT  = 2'b10,
    GM_OFF  = 2'b11
  } gm_mode_e;

  // Clock cycles covering a duration in ns, rounded up.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned period_ps);
    return (ns * 1000 + period_ps - 1) / period_ps;
  endfunction

  // True once the low run that will exist after this edge reaches the gap.
  function automatic logic gap_reached(input int unsigned low_run,
                                       input int unsigned gap);
    return (low_run + 1) >= gap;
  endfunction

endpackage

// File: rtl/gml_sync_edge.sv
module gml_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic sync_out,
  output logic rise_evt
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= raw_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign sync_out = chain[STAGES-1];
  assign rise_evt = chain[STAGES-1] & ~last_q;

  // a rising event is one cycle wide
  p_rise_single_r8: assert property (@(posedge clk) disable iff (rst)
    rise_evt |=> !rise_evt);

endmodule

// File: rtl/gml_mode_ctrl.sv
module gml_mode_ctrl
  import gml_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic [1:0] mode_req,
  input  logic     q_s,
  input  logic     q_rise,
  output gm_mode_e act_q,
  output gm_mode_e act_n,
  output logic     hold_n,
  output logic     mode_chg
);
  logic hold_q;

  always_comb begin
    mode_chg = (gm_mode_e'(mode_req) != act_q) && !q_s;
    act_n    = mode_chg ? gm_mode_e'(mode_req) : act_q;
    if (q_rise)        hold_n = 1'b0;
    else if (mode_chg) hold_n = 1'b1;
    else               hold_n = hold_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= GM_SAME;
      hold_q <= 1'b1;
    end else begin
      act_q  <= act_n;
      hold_q <= hold_n;
    end
  end

  p_switch_low_r8: assert property (@(posedge clk) disable iff (rst)
    (act_q != $past(act_q)) |-> !$past(q_s));

  p_hold_after_chg_r8: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> hold_q);

endmodule

// File: rtl/gml_alt_steer.sv
module gml_alt_steer (
  input  logic clk,
  input  logic rst,
  input  logic mode_chg,
  input  logic q_rise,
  input  logic alt_on,
  output logic sel_n
);
  logic tog_q, tog_n, sel_q;

  always_comb begin
    sel_n = q_rise ? tog_q : sel_q;
    if (mode_chg)            tog_n = 1'b0;
    else if (q_rise && alt_on) tog_n = ~tog_q;
    else                     tog_n = tog_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      tog_q <= tog_n;
      sel_q <= sel_n;
    end
  end

  p_clear_on_change_r9: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> !tog_q);

  p_steer_flip_r6: assert property (@(posedge clk) disable iff (rst)
    (q_rise && alt_on && !mode_chg) |=> (tog_q != $past(tog_q)));

endmodule

// File: rtl/gml_gap_timer.sv
module gml_gap_timer #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            gate_a,
  input  logic            gate_b,
  input  logic [DT_W-1:0] gap_eff,
  output logic            gap_ok
);
  import gml_pkg::*;
  localparam logic [DT_W-1:0] CNT_MAX = {DT_W{1'b1}};

  logic [DT_W-1:0] low_run;
  logic            any_on;

  assign any_on = gate_a | gate_b;
  assign gap_ok = !any_on && gap_reached(int'(low_run), int'(gap_eff));

  always_ff @(posedge clk) begin
    if (rst)                     low_run <= '0;
    else if (any_on)             low_run <= '0;
    else if (low_run != CNT_MAX) low_run <= low_run + 1'b1;
  end

  p_run_restart_r4: assert property (@(posedge clk) disable iff (rst)
    any_on |=> (low_run == '0));

endmodule

// File: rtl/gml_gate_mode.sv
module gml_gate_mode #(
  parameter int DT_W     = 8,
  parameter int CLK_PS   = 5000,
  parameter int GAP_NS   = 150,
  parameter int SYNC_LEN = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pwm_in,
  input  logic [1:0]      mode_sel,
  input  logic [DT_W-1:0] gap_cycles,
  output logic            gate_a,
  output logic            gate_b
);
  import gml_pkg::*;

  localparam int              GAP_DEF_I = int'(ns_to_cycles(GAP_NS, CLK_PS));
  localparam logic [DT_W-1:0] GAP_DEF   = GAP_DEF_I[DT_W-1:0];

  logic            q_s, q_rise, hold_n, mode_chg, sel_n, gap_ok;
  logic            ga_n, gb_n;
  gm_mode_e        act_q, act_n;
  logic [DT_W-1:0] gap_eff;

  assign gap_eff = (gap_cycles == '0) ? GAP_DEF : gap_cycles;

  gml_sync_edge #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst(rst), .raw_in(pwm_in), .sync_out(q_s), .rise_evt(q_rise)
  );

  gml_mode_ctrl u_mode (
    .clk(clk), .rst(rst), .mode_req(mode_sel), .q_s(q_s), .q_rise(q_rise),
    .act_q(act_q), .act_n(act_n), .hold_n(hold_n), .mode_chg(mode_chg)
  );

  gml_alt_steer u_alt (
    .clk(clk), .rst(rst), .mode_chg(mode_chg), .q_rise(q_rise),
    .alt_on(act_n == GM_ALT), .sel_n(sel_n)
  );

  gml_gap_timer #(.DT_W(DT_W)) u_gap (
    .clk(clk), .rst(rst), .gate_a(gate_a), .gate_b(gate_b),
    .gap_eff(gap_eff), .gap_ok(gap_ok)
  );

  always_comb begin
    ga_n = 1'b0;
    gb_n = 1'b0;
    if (!hold_n) begin
      unique case (act_n)
        GM_SAME: begin
          ga_n = q_s;
          gb_n = q_s;
        end
        GM_COMP: begin
          if (q_s) ga_n = gate_a | gap_ok;
          else     gb_n = gate_b | gap_ok;
        end
        GM_ALT: begin
          ga_n = q_s & ~sel_n;
          gb_n = q_s &  sel_n;
        end
        default: begin
          ga_n = 1'b0;
          gb_n = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_a <= 1'b0;
      gate_b <= 1'b0;
    end else begin
      gate_a <= ga_n;
      gate_b <= gb_n;
    end
  end

  p_reset_low_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!gate_a && !gate_b));

  p_same_pair_r2: assert property (@(posedge clk) disable iff (rst)
    (act_q == GM_SAME) |-> (gate_a == gate_b));

  p_no_overlap_r3: assert property (@(posedge clk) disable iff (rst)
    (act_q != GM_SAME) |-> !(gate_a && gate_b));

  p_a_after_gap_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(gate_a) && act_q == GM_COMP) |-> $past(!gate_b));

  p_b_after_gap_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(gate_b) && act_q == GM_COMP) |-> $past(!gate_a));

  p_alt_one_hot_r6: assert property (@(posedge clk) disable iff (rst)
    (act_q == GM_ALT) |-> $onehot0({gate_a, gate_b}));

  p_off_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (act_q == GM_OFF) |-> (!gate_a && !gate_b));

endmodule

// File: tb/test_gml_gate_mode.sv
`timescale 1ns/1ps
module test_gml_gate_mode;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwm_in = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic [7:0] gap_cycles = 8'd0;
  logic       gate_a, gate_b;

  int checks = 0, failures = 0, cycles = 0;

  gml_gate_mode i_gml_gate_mode (
    .clk(clk), .rst(rst), .pwm_in(pwm_in), .mode_sel(mode_sel),
    .gap_cycles(gap_cycles), .gate_a(gate_a), .gate_b(gate_b)
  );

  always #2.5 clk = ~clk;

  // ---------------- behavioural reference ----------------
  bit q_hist[$];              // raw samples, newest at front
  int m_mode = 0, m_toggle = 0, m_owner = 0, m_low = 0;
  bit m_wait = 1, m_a = 0, m_b = 0, m_prev_seen = 0;

  always @(posedge clk) begin
    bit seen, up, chg, na, nb, want;
    int gap;
    if (rst) begin
      q_hist = {}; m_mode = 0; m_toggle = 0; m_owner = 0; m_low = 0;
      m_wait = 1; m_a = 0; m_b = 0; m_prev_seen = 0;
    end else begin
      seen = (q_hist.size() >= 2) ? q_hist[1] : 1'b0;
      up   = seen && !m_prev_seen;
      chg  = (int'(mode_sel) != m_mode) && !seen;
      if (chg) m_mode = int'(mode_sel);
      if (up) m_wait = 0; else if (chg) m_wait = 1;
      if (up) m_owner = m_toggle;
      if (chg) m_toggle = 0;
      else if (up && m_mode == 2) m_toggle = 1 - m_toggle;
      gap = (gap_cycles == 0) ? 30 : int'(gap_cycles);
      na = 0; nb = 0;
      if (!m_wait) begin
        case (m_mode)
          0: begin na = seen; nb = seen; end
          1: begin
            want = (!m_a && !m_b && (m_low + 1 >= gap));
            if (seen) na = m_a || want; else nb = m_b || want;
          end
          2: begin na = seen && m_owner == 0; nb = seen && m_owner == 1; end
          default: ;
        endcase
      end
      if (m_a || m_b) m_low = 0; else if (m_low < 255) m_low++;
      m_a = na; m_b = nb;
      m_prev_seen = seen;
      q_hist.push_front(pwm_in);
      if (q_hist.size() > 4) void'(q_hist.pop_back());
    end
  end

  // ---------------- monitors and per-cycle compare ----------------
  int rises_a = 0, rises_b = 0, first_gate = 0, both_low = 0, last_gap = -1;
  int last_up = 0, high_seen = 0;
  bit pa = 0, pb = 0;

  function automatic string tag_of(int md, bit w);
    if (rst) return "R1";
    if (w)   return "R8";
    case (md)
      0: return "R2";
      1: return "R3";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  always @(negedge clk) begin
    cycles++;
    checks++;
    if (gate_a !== m_a || gate_b !== m_b) begin
      failures++;
      $display("FAIL %s cycle %0d gates a=%b b=%b expected a=%b b=%b",
               tag_of(m_mode, m_wait), cycles, gate_a, gate_b, m_a, m_b);
    end
    if (gate_a && !pa) begin
      rises_a++;
      if (first_gate == 0) first_gate = 1;
      if (last_up == 2) last_gap = both_low;
      last_up = 1;
    end
    if (gate_b && !pb) begin
      rises_b++;
      if (first_gate == 0) first_gate = 2;
      if (last_up == 1) last_gap = both_low;
      last_up = 2;
    end
    if (gate_a || gate_b) begin both_low = 0; high_seen++; end
    else both_low++;
    pa = gate_a; pb = gate_b;
  end

  initial begin
    #900_000;
    failures++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- stimulus ----------------
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int hi, int lo);
    @(negedge clk); #1 pwm_in = 1'b1;
    repeat (hi) @(negedge clk);
    #1 pwm_in = 1'b0;
    repeat (lo - 1) @(negedge clk);
  endtask

  task automatic expect_int(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    rises_a = 0; rises_b = 0; first_gate = 0; last_gap = -1; last_up = 0;
    high_seen = 0;
  endtask

  initial begin
    idle(5);
    expect_int("R1", "gate_a in reset", int'(gate_a), 0);
    expect_int("R1", "gate_b in reset", int'(gate_b), 0);
    #1 rst = 1'b0;
    idle(10);
    expect_int("R1", "outputs high before first pulse", high_seen, 0);

    // R2 same-phase under several pulse shapes
    pulse(3, 4); pulse(10, 7); pulse(1, 5); pulse(25, 2); idle(6);
    expect_int("R2", "gate_a rises in same-phase", rises_a, 4);

    // R3/R5 complementary with explicit gap
    #1 gap_cycles = 8'd5; mode_sel = 2'b01;
    idle(8); clear_mon();
    repeat (3) pulse(60, 60);
    expect_int("R5", "gap length with count 5", last_gap, 5);
    pulse(3, 3); pulse(2, 40);  // shorter than the gap
    #1 gap_cycles = 8'd1;
    clear_mon(); repeat (2) pulse(20, 20);
    expect_int("R5", "gap length with count 1", last_gap, 1);

    // R10 default gap
    #1 gap_cycles = 8'd0;
    clear_mon(); repeat (2) pulse(80, 80);
    expect_int("R10", "default gap length", last_gap, 30);

    // R8/R9 switch to alternating requested while q is high
    @(negedge clk); #1 pwm_in = 1'b1;
    idle(4);
    #1 mode_sel = 2'b10;
    idle(20);
    #1 pwm_in = 1'b0;
    idle(12);
    clear_mon();
    repeat (6) pulse(10, 10);
    idle(5);
    expect_int("R9", "first alternating gate (1=A)", first_gate, 1);
    expect_int("R6", "pulses on gate A", rises_a, 3);
    expect_int("R6", "pulses on gate B", rises_b, 3);

    // R9 re-entry resets the toggle: leave after an odd count of pulses
    pulse(10, 10);
    #1 mode_sel = 2'b00; idle(3); pulse(5, 10);
    #1 mode_sel = 2'b10; idle(3);
    clear_mon(); pulse(8, 10); idle(5);
    expect_int("R9", "first gate after re-entry (1=A)", first_gate, 1);

    // R7 reserved select
    #1 mode_sel = 2'b11; idle(3);
    clear_mon(); repeat (4) pulse(12, 9); idle(5);
    expect_int("R7", "high cycles in reserved select", high_seen, 0);

    // R8 hold after change: gates stay low until the next rise
    #1 mode_sel = 2'b01; gap_cycles = 8'd4;
    clear_mon(); idle(40);
    expect_int("R8", "high cycles while waiting for rise", high_seen, 0);
    pulse(30, 30); idle(5);
    expect_int("R3", "complementary A pulses", rises_a, 1);

    // back to same-phase with a mid-pulse request
    @(negedge clk); #1 pwm_in = 1'b1; idle(6);
    #1 mode_sel = 2'b00; idle(10);
    #1 pwm_in = 1'b0; idle(8);
    pulse(4, 6); pulse(9, 3); idle(8);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule